// File: doc/BRIEF.md
# Triangle-Wave Buffered PWM Generator

This block produces one pulse-width modulated output from an up/down counter. Once started, the counter climbs from zero to a programmed period value and then descends back to zero, so each PWM period is symmetric about its peak. The counter advances only on clock cycles where an external clock-enable pulse is high, which lets a shared prescaler set the count rate.

Software writes a duty value into a staging buffer through a small register port. The staged value is copied into the active duty register only when the counter steps down from 1 to 0. That moment, the bottom of the triangle, is the period boundary. The same boundary raises a sticky status flag, which software clears by writing 1 to it. The output is a registered comparison of the counter against the active duty.

Right after a start, the output is frozen at its last value for one whole triangle period. This keeps a stale duty from reaching the pin before the first buffered value has been loaded. The count direction, the flag, the period, the staged duty and the live count can all be read back through the register port.

Top module: `tpwm_top`

## Requirements
- R1: After a start with period 4 and the tick input high every clock, the count read at address 3 runs 1,2,3,4,3,2,1,0,1,... advancing once per clock, and each step changes the count by exactly one.
- R2: Bit 2 of address 0 reads 1 when the most recent counter step went up, and after reset or a start. It reads 0 when the most recent step went down, including at the bottom value 0.
- R3: A write to address 2 updates only the staging buffer. The active duty takes the buffered value at the boundary, which is a counter step from 1 to 0, and at no other time.
- R4: Bit 1 of address 0 is set at every boundary and stays set until a write to address 0 with bit 1 at 1. If that clearing write lands in the same clock as a boundary, the flag stays set.
- R5: Once started and past its first period, the output is high in a clock exactly when the counter held in the previous clock was below the active duty, or when the active duty is at least the period. Duty 0 never drives the output high, and duty equal to or above the period drives it high always.
- R6: From a start until the clock after the first boundary, the output keeps the level it had when the start was written.
- R7: The counter changes only in clocks where the tick input is high and bit 0 (run) of address 0 is 1. Otherwise it holds.
- R8: With a period of 0 (address 1), the counter stays at 0 even while running and ticking.
- R9: Writing 1 to bit 0 of address 0 while run is 0 starts the block. In that clock the counter goes to 0 and the direction goes up. Writing 0 to that bit stops counting.
- R10: After reset, run, flag, period, staged duty and count all read 0, the direction bit reads 1, and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled count-enable pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control/status, 1 period, 2 duty buffer, 3 count |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for bus_addr (combinational) |
| pwm_o | output | 1 | PWM output |

## Verification
The boundary sets the flag, and a software clear of that flag can land in the very same clock. The bench counts clocks from a known start so that one clearing write hits the exact clock in which the counter steps from 1 to 0. It then requires the flag to read 1 afterwards. It also checks that an ordinary clear one clock later reads 0. In the same way, a duty write placed mid-period must leave the high-time of the current period untouched and show up only in the next period.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_PERIOD = 2'd1,
      REG_DUTY   = 2'd2,
      REG_COUNT  = 2'd3
   } tpwm_reg_e;

   localparam int CTRL_RUN_BIT  = 0;
   localparam int CTRL_FLAG_BIT = 1;
   localparam int CTRL_DIR_BIT  = 2;
   localparam int CTRL_BITS     = 3;
endpackage

// File: rtl/tpwm_regs.sv
module tpwm_regs
   import tpwm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bus_wr,
   input  logic [1:0]   bus_addr,
   input  logic [W-1:0] bus_wdata,
   output logic [W-1:0] bus_rdata,
   input  logic         boundary,
   input  logic         dir_up,
   input  logic [W-1:0] cnt,
   output logic         run,
   output logic         start,
   output logic         flag,
   output logic         flag_clr,
   output logic [W-1:0] period,
   output logic [W-1:0] duty_buf
);
   tpwm_reg_e sel;
   logic      wr_ctrl;

   assign sel      = tpwm_reg_e'(bus_addr);
   assign wr_ctrl  = bus_wr && (sel == REG_CTRL);
   assign start    = wr_ctrl && bus_wdata[CTRL_RUN_BIT] && !run;
   assign flag_clr = wr_ctrl && bus_wdata[CTRL_FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         period   <= '0;
         duty_buf <= '0;
      end else if (bus_wr) begin
         case (sel)
            REG_CTRL:   run      <= bus_wdata[CTRL_RUN_BIT];
            REG_PERIOD: period   <= bus_wdata;
            REG_DUTY:   duty_buf <= bus_wdata;
            default:    ;
         endcase
      end
   end

   // set has priority over a software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag <= 1'b0;
      else if (boundary)  flag <= 1'b1;
      else if (flag_clr)  flag <= 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      case (sel)
         REG_CTRL: begin
            bus_rdata[CTRL_RUN_BIT]  = run;
            bus_rdata[CTRL_FLAG_BIT] = flag;
            bus_rdata[CTRL_DIR_BIT]  = dir_up;
         end
         REG_PERIOD: bus_rdata = period;
         REG_DUTY:   bus_rdata = duty_buf;
         REG_COUNT:  bus_rdata = cnt;
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tpwm_counter.sv
module tpwm_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         start,
   input  logic         tick_en,
   input  logic [W-1:0] period,
   output logic [W-1:0] cnt,
   output logic         dir_up,
   output logic         boundary
);
   localparam logic [W-1:0] ONE = W'(1);

   logic advance;
   logic step_down;

   assign advance   = run && tick_en && (period != '0);
   assign step_down = dir_up ? (cnt >= period) : (cnt != '0);
   assign boundary  = advance && step_down && (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         dir_up <= 1'b1;
      end else if (start) begin
         cnt    <= '0;
         dir_up <= 1'b1;
      end else if (advance) begin
         cnt    <= step_down ? (cnt - ONE) : (cnt + ONE);
         dir_up <= !step_down;
      end
   end
endmodule

// File: rtl/tpwm_out.sv
module tpwm_out #(
   parameter int W          = 16,
   parameter bit OUT_INVERT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         boundary,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] period,
   input  logic [W-1:0] duty_buf,
   output logic [W-1:0] active_duty,
   output logic         primed,
   output logic         pwm_lvl,
   output logic         pwm_o
);
   logic cmp_hi;

   assign cmp_hi = (cnt < active_duty) || (active_duty >= period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_duty <= '0;
         primed      <= 1'b0;
      end else begin
         if (boundary) active_duty <= duty_buf;
         if (start)         primed <= 1'b0;
         else if (boundary) primed <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pwm_lvl <= 1'b0;
      else if (primed) pwm_lvl <= cmp_hi;
   end

   generate
      if (OUT_INVERT) begin : g_inv
         assign pwm_o = ~pwm_lvl;
      end else begin : g_true
         assign pwm_o = pwm_lvl;
      end
   endgenerate
endmodule

// File: rtl/tpwm_top.sv
module tpwm_top
   import tpwm_pkg::*;
#(
   parameter int W          = 16,
   parameter bit OUT_INVERT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_en,
   input  logic         bus_wr,
   input  logic [1:0]   bus_addr,
   input  logic [W-1:0] bus_wdata,
   output logic [W-1:0] bus_rdata,
   output logic         pwm_o
);
   generate
      if (W < CTRL_BITS) begin : g_bad_width
         $error("tpwm_top: W must hold the control bits");
      end
   endgenerate

   logic         run, start, flag, flag_clr;
   logic         boundary, dir_up, primed, pwm_lvl;
   logic [W-1:0] cnt, period, duty_buf, active_duty;

   tpwm_regs #(.W(W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .boundary(boundary),
      .dir_up(dir_up), .cnt(cnt), .run(run), .start(start), .flag(flag),
      .flag_clr(flag_clr), .period(period), .duty_buf(duty_buf)
   );

   tpwm_counter #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .start(start), .tick_en(tick_en),
      .period(period), .cnt(cnt), .dir_up(dir_up), .boundary(boundary)
   );

   tpwm_out #(.W(W), .OUT_INVERT(OUT_INVERT)) u_out (
      .clk(clk), .rst_n(rst_n), .start(start), .boundary(boundary),
      .cnt(cnt), .period(period), .duty_buf(duty_buf),
      .active_duty(active_duty), .primed(primed), .pwm_lvl(pwm_lvl),
      .pwm_o(pwm_o)
   );
endmodule

// File: rtl/tpwm_chk.sv
module tpwm_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick_en,
   input logic         run,
   input logic         start,
   input logic         boundary,
   input logic         flag,
   input logic         flag_clr,
   input logic         primed,
   input logic         pwm_lvl,
   input logic [W-1:0] cnt,
   input logic [W-1:0] period,
   input logic [W-1:0] active_duty
);
   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick_en && period != '0 && !start) |=> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1))); // R1
   AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(active_duty)); // R3
   AST_FLAG_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |=> flag); // R4
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag); // R4
   AST_RETAIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      !primed |=> $stable(pwm_lvl)); // R6
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!(run && tick_en) && !start) |=> $stable(cnt)); // R7
   AST_ZERO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (period == '0 && !start) |=> $stable(cnt)); // R8
   AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt == '0)); // R9
endmodule

bind tpwm_top tpwm_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run), .start(start),
   .boundary(boundary), .flag(flag), .flag_clr(flag_clr), .primed(primed),
   .pwm_lvl(pwm_lvl), .cnt(cnt), .period(period), .active_duty(active_duty)
);

// File: tb/sim_tpwm_top.sv
`timescale 1ns/1ps
module sim_tpwm_top;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_en = 1'b1;
   logic         bus_wr = 1'b0;
   logic [1:0]   bus_addr = 2'd0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic         pwm_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   tpwm_top #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_o(pwm_o)
   );

   always #4 clk = ~clk;

   // period, duty, expected high clocks per triangle period (R5)
   localparam int NVEC = 12;
   localparam int VEC [NVEC][3] = '{
      '{4, 0, 0}, '{4, 1, 1}, '{4, 2, 3}, '{4, 3, 5}, '{4, 4, 8}, '{4, 9, 8},
      '{3, 2, 3}, '{1, 1, 2}, '{1, 0, 0}, '{7, 3, 5}, '{5, 5, 10}, '{6, 1, 1}
   };

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic bus_write(int addr, int data);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 2'(addr); bus_wdata = W'(data);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(int addr, output int val);
      bus_addr = 2'(addr);
      #1;
      val = int'(bus_rdata);
   endtask

   function automatic int tri_at(int n, int p);
      int m = n % (2 * p);
      return (m <= p) ? m : 2 * p - m;
   endfunction

   task automatic count_highs(int p, output int highs);
      highs = 0;
      for (int k = 0; k < 2 * p; k++) begin
         @(negedge clk);
         highs += int'(pwm_o);
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int v, d, h;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      rd(0, v); chk("R10 ctrl", v, 4);
      rd(1, v); chk("R10 period", v, 0);
      rd(2, v); chk("R10 duty", v, 0);
      rd(3, v); chk("R10 count", v, 0);
      chk("R10 pwm", int'(pwm_o), 0);

      // R1 R2 R4 R9: sequence, direction, flag and set-versus-clear
      bus_write(1, 4);
      bus_write(2, 2);
      bus_write(0, 1);
      rd(3, v); chk("R9 count at start", v, 0);
      for (int n = 1; n <= 17; n++) begin
         @(negedge clk);
         bus_wr = 1'b0;
         rd(3, v); chk("R1 count", v, tri_at(n, 4));
         rd(0, d);
         h = tri_at(n, 4);
         chk("R2 dir", (d >> 2) & 1, (h >= 1 && (n % 8) >= 1 && (n % 8) <= 4) ? 1 : 0);
         if (n == 7 || n == 10 || n == 15 || n == 17) chk("R4 flag low", (d >> 1) & 1, 0);
         if (n == 8 || n == 9) chk("R4 flag set", (d >> 1) & 1, 1);
         if (n == 16) chk("R4 set beats clear", (d >> 1) & 1, 1);
         if (n == 9 || n == 15 || n == 16) begin
            bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = W'(3);
         end
      end
      bus_wr = 1'b0;

      // R5 duty table
      for (int i = 0; i < NVEC; i++) begin
         bus_write(0, 0);
         bus_write(1, VEC[i][0]);
         bus_write(2, VEC[i][1]);
         bus_write(0, 1);
         repeat (2 * VEC[i][0]) @(negedge clk);
         count_highs(VEC[i][0], h);
         chk($sformatf("R5 p=%0d d=%0d highs", VEC[i][0], VEC[i][1]), h, VEC[i][2]);
      end

      // R3 buffered duty: mid-period write waits for the boundary
      bus_write(0, 0);
      bus_write(1, 4);
      bus_write(2, 2);
      bus_write(0, 1);
      repeat (8) @(negedge clk);
      h = 0;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         bus_wr = 1'b0;
         h += int'(pwm_o);
         if (k == 2) begin bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = W'(4); end
      end
      chk("R3 current period unchanged", h, 3);
      count_highs(4, h);
      chk("R3 next period uses buffer", h, 8);

      // R6 retention after a restart
      repeat (4) @(negedge clk);
      chk("R6 pre-stop level", int'(pwm_o), 1);
      bus_write(0, 0);
      bus_write(2, 0);
      bus_write(0, 1);
      for (int k = 1; k <= 16; k++) begin
         @(negedge clk);
         chk($sformatf("R6 level k=%0d", k), int'(pwm_o), (k <= 8) ? 1 : 0);
      end

      // R7 tick gating
      tick_en = 1'b0;
      rd(3, d);
      repeat (5) @(negedge clk);
      rd(3, v); chk("R7 hold without tick", v, d);
      bus_write(0, 0);
      tick_en = 1'b1;
      rd(3, d);
      repeat (4) @(negedge clk);
      rd(3, v); chk("R7 hold when stopped", v, d);

      // R8 zero period
      bus_write(1, 0);
      bus_write(0, 1);
      repeat (6) @(negedge clk);
      rd(3, v); chk("R8 zero period count", v, 0);

      // R10 reset mid-run
      bus_write(1, 5);
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(3, v); chk("R10 count after reset", v, 0);
      rd(0, v); chk("R10 ctrl after reset", v, 4);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule